// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a processor write port and a slower memory write port. Each write command carries everything needed to finish it, an address and a data word. The block therefore puts the command in a small in-order queue. The queue then drains to memory, one entry per memory handshake. The processor does not have to wait for the memory to finish before it continues.

A mode input selects when the processor is told that a write is complete. In posted mode the acknowledge comes in the same cycle that the queue takes the write. In non-posted mode the block holds one write at a time and gives the acknowledge only in the cycle the memory takes that write. A full queue holds back further writes until an entry drains. An empty flag lets a fence wait until every posted write has reached memory.

The processor raises `wr_req_i` with its address and data and keeps them steady until it sees `wr_ack_o`. The memory side uses a valid/ready handshake.

Top module: `posted_wr_buf`

## Requirements
- R1: While reset is applied and in the first cycle after it, `empty_o` is 1, `mem_valid_o` is 0 and `wr_ack_o` is 0 when no request is present.
- R2: In posted mode (`posted_mode_i`=1), a request that finds fewer than DEPTH entries queued and no non-posted write outstanding is acknowledged combinationally in that same cycle and queued.
- R3: While DEPTH entries are queued, a posted request is neither acknowledged nor queued. It is accepted in the first cycle whose starting occupancy is below DEPTH, which is the cycle after a drain.
- R4: Queued writes reach the memory port in arrival order, with address and data unchanged.
- R5: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the next cycle keeps `mem_valid_o` at 1 with the same address and data.
- R6: In non-posted mode (`posted_mode_i`=0), at most one write is outstanding. Its acknowledge is given only in the cycle that the memory handshake (`mem_valid_o` and `mem_ready_i` both 1) retires that write.
- R7: In non-posted mode, a request is taken only when the queue is empty. Writes left over from posted mode drain first, and no acknowledge is given while they drain.
- R8: `empty_o` is 1 exactly when no entry is queued.
- R9: `mem_valid_o` is 1 exactly when at least one entry is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| posted_mode_i | input | 1 | 1: acknowledge on enqueue; 0: acknowledge on memory completion |
| wr_req_i | input | 1 | Processor write request, held until acknowledged |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| wr_ack_o | output | 1 | Write acknowledge |
| mem_valid_o | output | 1 | Head entry presented to memory |
| mem_addr_o | output | ADDR_W | Head entry address |
| mem_data_o | output | DATA_W | Head entry data |
| mem_ready_i | input | 1 | Memory takes the presented write |
| empty_o | output | 1 | No posted writes pending |

## Verification
If the occupancy count goes wrong, it shows up at once in `empty_o` and `mem_valid_o`. It also shows up in the full-queue stall as an acknowledge that comes one write too early or too late. A pointer that goes wrong shows up at the next memory handshake, as an address and data pair that is out of arrival order. If the outstanding flag for non-posted mode is stuck, the block either acknowledges twice or never acknowledges. This is visible within a few cycles, because the bench mixes ready patterns with switches between modes.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    ACK_ON_DONE  = 1'b0,
    ACK_ON_QUEUE = 1'b1
  } ack_mode_e;

  function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 24,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_i) wr_ptr_q <= PTR_W'(pwb_pkg::wrap_inc(int'(wr_ptr_q), DEPTH));
      if (pop_i)  rd_ptr_q <= PTR_W'(pwb_pkg::wrap_inc(int'(rd_ptr_q), DEPTH));
      case ({push_i, pop_i})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  // storage needs no reset; validity is tracked by fill_q
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign fill_o  = fill_q;
  assign full_o  = (fill_q == CNT_W'(DEPTH));
  assign empty_o = (fill_q == '0);
endmodule

// File: rtl/pwb_ack_ctrl.sv
module pwb_ack_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic posted_mode_i,
  input  logic req_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic drain_i,
  output logic push_o,
  output logic ack_o,
  output logic np_busy_o
);
  logic np_busy_q;
  logic posted_acc, np_acc, np_done;

  // posted path blocked while a non-posted write is in flight so a held
  // request is never queued twice after a mode change
  assign posted_acc = posted_mode_i & req_i & ~full_i & ~np_busy_q;
  assign np_acc     = ~posted_mode_i & req_i & empty_i & ~np_busy_q;
  // np entry is always the head: it is only taken into an empty queue
  assign np_done    = np_busy_q & drain_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      np_busy_q <= 1'b0;
    else if (np_acc)  np_busy_q <= 1'b1;
    else if (np_done) np_busy_q <= 1'b0;
  end

  assign push_o    = posted_acc | np_acc;
  assign ack_o     = posted_acc | np_done;
  assign np_busy_o = np_busy_q;
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ENT_W = ADDR_W + DATA_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              posted_mode_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ack_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ready_i,
  output logic              empty_o
);
  logic             push, drain, full, empty, np_busy;
  logic [ENT_W-1:0] head;
  logic [CNT_W-1:0] fill_cnt;

  assign drain = ~empty & mem_ready_i;

  pwb_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i ({wr_addr_i, wr_data_i}),
    .pop_i       (drain),
    .head_o      (head),
    .fill_o      (fill_cnt),
    .full_o      (full),
    .empty_o     (empty)
  );

  pwb_ack_ctrl u_ack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .posted_mode_i (posted_mode_i),
    .req_i         (wr_req_i),
    .full_i        (full),
    .empty_i       (empty),
    .drain_i       (drain),
    .push_o        (push),
    .ack_o         (wr_ack_o),
    .np_busy_o     (np_busy)
  );

  assign mem_valid_o = ~empty;
  assign mem_addr_o  = head[ENT_W-1:DATA_W];
  assign mem_data_o  = head[DATA_W-1:0];
  assign empty_o     = empty;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              posted_mode_i,
  input logic              wr_req_i,
  input logic              wr_ack_o,
  input logic              mem_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              mem_ready_i,
  input logic              empty_o,
  input logic [CNT_W-1:0]  fill_i,
  input logic              np_busy_i
);
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> wr_req_i); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CNT_W'(DEPTH)); // R3

  AST_FULL_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (posted_mode_i && fill_i == CNT_W'(DEPTH)) |-> !wr_ack_o); // R3

  AST_HOLD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R5

  AST_NP_ACK_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!posted_mode_i && wr_ack_o) |-> (mem_valid_o && mem_ready_i)); // R6

  AST_NP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    np_busy_i |-> (fill_i == CNT_W'(1))); // R6

  AST_NP_WAIT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!posted_mode_i && !np_busy_i && !empty_o) |-> !wr_ack_o); // R7

  AST_EMPTY_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !mem_valid_o); // R9
endmodule

bind posted_wr_buf pwb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .posted_mode_i (posted_mode_i),
  .wr_req_i      (wr_req_i),
  .wr_ack_o      (wr_ack_o),
  .mem_valid_o   (mem_valid_o),
  .mem_addr_o    (mem_addr_o),
  .mem_data_o    (mem_data_o),
  .mem_ready_i   (mem_ready_i),
  .empty_o       (empty_o),
  .fill_i        (fill_cnt),
  .np_busy_i     (np_busy)
);

// File: tb/tb_posted_wr_buf.sv
`timescale 1ns/1ps
module tb_posted_wr_buf;
  localparam int DEPTH = 4, AW = 8, DW = 16;
  localparam real TCK = 5.0;

  logic clk = 0, rst_n = 0;
  logic posted = 1, req = 0, ready = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic ack, mvalid, empty;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mdata;

  always #(TCK/2) clk = ~clk;

  posted_wr_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .posted_mode_i(posted),
    .wr_req_i(req), .wr_addr_i(addr), .wr_data_i(data), .wr_ack_o(ack),
    .mem_valid_o(mvalid), .mem_addr_o(maddr), .mem_data_o(mdata),
    .mem_ready_i(ready), .empty_o(empty)
  );

  int vecs = 0, errs = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] qa [DEPTH];
  logic [DW-1:0] qd [DEPTH];
  int head = 0, size = 0, seq = 0;
  bit np_pend = 0, req_active = 0, stall_prev = 0;
  logic [AW-1:0] prev_a;
  logic [DW-1:0] prev_d;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit want, input bit rdy, input bit mode);
    bit acc, exp_ack, drn;
    string tag;
    @(negedge clk);
    posted = mode;
    ready  = rdy;
    if (!req_active && want) begin
      req_active = 1;
      seq++;
      addr = AW'(seq * 37);
      data = DW'((seq * 1021) ^ 16'hA5A5);
    end
    req = req_active;
    #1;
    drn = (size > 0) && rdy;
    if (mode) acc = req && size < DEPTH && !np_pend;
    else      acc = req && size == 0 && !np_pend;
    exp_ack = (mode && acc) || (np_pend && drn);
    if (mode && req && size == DEPTH)        tag = "R3";
    else if (!mode && req && size > 0 && !np_pend) tag = "R7";
    else if (mode)                           tag = "R2";
    else                                     tag = "R6";
    chk(ack === exp_ack, tag, ack, exp_ack);
    chk(mvalid === (size > 0), "R9", mvalid, size > 0);
    chk(empty === (size == 0), "R8", empty, size == 0);
    if (size > 0) begin
      chk(maddr === qa[head] && mdata === qd[head], "R4",
          {maddr, mdata}, {qa[head], qd[head]});
    end
    if (stall_prev) chk(mvalid && maddr === prev_a && mdata === prev_d, "R5",
                        {maddr, mdata}, {prev_a, prev_d});
    stall_prev = mvalid && !rdy;
    prev_a = maddr;
    prev_d = mdata;
    if (drn) begin
      head = (head + 1) % DEPTH;
      size--;
      np_pend = 0;
    end
    if (acc) begin
      qa[(head + size) % DEPTH] = addr;
      qd[(head + size) % DEPTH] = data;
      size++;
      if (!mode) np_pend = 1;
    end
    if (ack) req_active = 0;
  endtask

  initial begin
    #(TCK * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(TCK * 2.2);
    // R1: outputs during reset
    chk(empty === 1 && mvalid === 0 && ack === 0, "R1", {empty, mvalid, ack}, 3'b100);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(empty === 1 && mvalid === 0 && ack === 0, "R1", {empty, mvalid, ack}, 3'b100);
    // fill and hold full with memory stalled (R2, R3, R5)
    for (int c = 0; c < 8; c++) step(1, 0, 1);
    // posted sweep over ready patterns (R3, R4)
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 50; c++)
        step((c % 5) != 4, ((c + p) % (p + 2)) != 0, 1);
    // non-posted sweep (R6, R7)
    for (int p = 0; p < 3; p++)
      for (int c = 0; c < 50; c++)
        step((c % 4) != 3, ((c * (p + 1)) % 3) != 1, 0);
    // mode toggles with residual posted writes
    for (int c = 0; c < 200; c++)
      step((c % 6) != 5, (c % 4) != 0 && (c % 9) != 2, ((c / 7) % 2) == 0);
    // drain to empty
    for (int c = 0; c < 12; c++) step(0, 1, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule